// File: doc/BRIEF.md
# ADC Sequence Control and Interrupt Pacing

This block is the control half of an analog-to-digital conversion sequencer. A CPU reads and writes one 16-bit control word over a simple bus strobe interface. From the clock-select field it derives a one-cycle conversion tick in the system clock domain. A software start launches a pass over channel slots, from a first-slot input to a last-slot input. Each slot goes through an acquisition phase and then a fixed conversion phase, and a done pulse ends the slot. In continuous mode the pass repeats until reset. In single mode the block returns to idle after the last slot.

Completed samples are counted, and a sticky data-available flag is raised at a programmable interval. An enable bit turns that flag into an interrupt request. The block also drives a reference-select output. The converter itself is represented only by its timing: a slot takes (1 + optional extension) acquisition ticks plus 4 conversion ticks.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control word reads 0x3000, and `busy`, `data_avail` and `irq` are 0.
- R2: The read-back layout is: bits 14:12 clock select, 11:10 interval, 7 internal reference, 6 continuous, 5 interrupt enable, 3:0 acquisition extension. Bits 15, 9:8 and 4 always read 0, whatever was written; writing 0xFFFF reads back 0x7CEF.
- R3: Clock-select codes 000 to 011 read back as 011. Codes 100 to 111 read back as written.
- R4: `conv_tick` is a one-cycle pulse whose period is 16 system clocks for codes 000 to 100, and 32, 64 and 128 clocks for codes 101, 110 and 111. The divider restarts when the ratio changes.
- R5: While `busy` is 1, control writes are ignored.
- R6: A start when idle converts slots first..last in rising order. In single mode `busy` clears with the last slot's done pulse. A start while busy is ignored.
- R7: In continuous mode the slot after the last one is the first one again, and conversion keeps going.
- R8: Interval code 00 flags every sample, 01 the last slot of each pass, 10 every 12th sample and 11 every 16th sample, counted from the start.
- R9: `data_avail` stays set until `flag_clr` is pulsed. A flag event in the same cycle as the clear wins, and the flag stays set.
- R10: `irq` is 1 exactly when `data_avail` is 1 and the interrupt enable bit is 1.
- R11: With `acq_ext_en` at 1, each slot's acquisition phase lasts 1 + extension ticks. With it at 0 the extension field has no effect: in /16 mode samples are spaced 128 clocks (extension 3) against 80 clocks.
- R12: `ref_internal` is 1 when the internal-reference bit is 1, when the current slot is 6 or 7, or when `ext_temp_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_hit | input | 1 | Control register address match |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| sw_start | input | 1 | Software start pulse |
| flag_clr | input | 1 | Clears the data-available flag |
| slot_first | input | 4 | First slot of a pass |
| slot_last | input | 4 | Last slot of a pass |
| acq_ext_en | input | 1 | Enables the acquisition extension |
| ext_temp_mode | input | 1 | External temperature mode, forces internal reference |
| conv_tick | output | 1 | Conversion clock enable pulse |
| busy | output | 1 | Conversion in progress |
| cur_slot | output | 4 | Slot being converted |
| sample_done | output | 1 | One-cycle end-of-sample pulse |
| data_avail | output | 1 | Sticky data-available flag |
| irq | output | 1 | Interrupt request |
| ref_internal | output | 1 | Internal reference selected |

## Verification
A corrupted divider count or a wrong divide exponent shows up on the first `conv_tick` gap after a clock-select write. A lost or extra state in the slot stepper shows up as a wrong `cur_slot` on the next `sample_done`, or as a `busy` that fails to drop. Because every event counts completed samples, an off-by-one in the sample counter stays hidden until the 12th or 16th sample, when `data_avail` rises one sample early or late. The bench therefore walks each interval to its boundary and checks the flag after every sample.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef struct packed {
    logic [2:0] clk_sel;
    logic [1:0] intv;
    logic       iref;
    logic       cont;
    logic       ie;
    logic [3:0] acq;
  } ctl_t;

  localparam logic [1:0] INTV_EACH = 2'b00;
  localparam logic [1:0] INTV_PASS = 2'b01;
  localparam logic [1:0] INTV_N12  = 2'b10;
  localparam logic [1:0] INTV_N16  = 2'b11;

  localparam logic [2:0] CLK_SEL_RST   = 3'b011;
  localparam logic [2:0] CLK_SEL_FLOOR = 3'b011;

  typedef enum logic [1:0] {ST_IDLE, ST_ACQ, ST_CONV} seq_st_t;
endpackage

// File: rtl/adc_ctl_reg.sv
module adc_ctl_reg
  import adc_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        hit,
  input  logic        rd,
  input  logic        wr,
  input  logic [15:0] wdata,
  input  logic        busy,
  output ctl_t        ctl,
  output logic [15:0] rdata
);
  logic [2:0] sel_rb;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata[15], wdata[9:8], wdata[4]};
  assign sel_rb = (ctl.clk_sel < CLK_SEL_FLOOR) ? CLK_SEL_FLOOR : ctl.clk_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= '{clk_sel: CLK_SEL_RST, default: '0};
      rdata <= '0;
    end else begin
      if (hit && wr && !busy) begin
        ctl.clk_sel <= wdata[14:12];
        ctl.intv    <= wdata[11:10];
        ctl.iref    <= wdata[7];
        ctl.cont    <= wdata[6];
        ctl.ie      <= wdata[5];
        ctl.acq     <= wdata[3:0];
      end
      if (hit && rd)
        rdata <= {1'b0, sel_rb, ctl.intv, 2'b00, ctl.iref, ctl.cont, ctl.ie, 1'b0, ctl.acq};
    end
  end
endmodule

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int MIN_EXP = 4,
  parameter int MAX_EXP = 7,
  localparam int DIV_W = MAX_EXP
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  output logic       tick
);
  logic [2:0]       exp_w, exp_q;
  logic [DIV_W-1:0] cnt, div_m1;

  assign exp_w  = (sel < 3'(MIN_EXP)) ? 3'(MIN_EXP) : sel;
  assign div_m1 = DIV_W'((32'd1 << exp_w) - 32'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      exp_q <= 3'(MIN_EXP);
      tick  <= 1'b0;
    end else if (exp_w != exp_q) begin
      cnt   <= '0;
      exp_q <= exp_w;
      tick  <= 1'b0;
    end else begin
      tick <= (cnt == div_m1);
      cnt  <= (cnt == div_m1) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SLOT_W     = 4,
  parameter int CONV_TICKS = 4,
  parameter int ACQ_BASE   = 1,
  parameter int EXT_W      = 4,
  localparam int CNT_W = $clog2(ACQ_BASE + (1 << EXT_W) + CONV_TICKS) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              start,
  input  logic [SLOT_W-1:0] first,
  input  logic [SLOT_W-1:0] last,
  input  logic              cont,
  input  logic              acq_en,
  input  logic [EXT_W-1:0]  acq_ext,
  output logic              busy,
  output logic [SLOT_W-1:0] slot,
  output logic              done_p,
  output logic              last_p
);
  seq_st_t          st;
  logic [CNT_W-1:0] cnt, acq_len;

  assign acq_len = CNT_W'(ACQ_BASE) + (acq_en ? CNT_W'(acq_ext) : '0);
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      slot   <= '0;
      cnt    <= '0;
      done_p <= 1'b0;
      last_p <= 1'b0;
    end else begin
      done_p <= 1'b0;
      last_p <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          st   <= ST_ACQ;
          slot <= first;
          cnt  <= acq_len;
        end
        ST_ACQ: if (tick) begin
          if (cnt == CNT_W'(1)) begin
            st  <= ST_CONV;
            cnt <= CNT_W'(CONV_TICKS);
          end else cnt <= cnt - 1'b1;
        end
        ST_CONV: if (tick) begin
          if (cnt == CNT_W'(1)) begin
            done_p <= 1'b1;
            last_p <= (slot == last);
            if (slot == last) begin
              if (cont) begin
                st   <= ST_ACQ;
                slot <= first;
                cnt  <= acq_len;
              end else st <= ST_IDLE;
            end else begin
              st   <= ST_ACQ;
              slot <= slot + 1'b1;
              cnt  <= acq_len;
            end
          end else cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_irq_pace.sv
module adc_irq_pace
  import adc_seq_pkg::*;
#(
  parameter int GROUP_A = 12,
  parameter int GROUP_B = 16,
  localparam int CW = $clog2(GROUP_B + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       done,
  input  logic       last,
  input  logic [1:0] intv,
  input  logic       clr,
  output logic       flag
);
  logic [CW-1:0] cnt;
  logic          hit_a, hit_b, ev;

  assign hit_a = (intv == INTV_N12) && (cnt == CW'(GROUP_A - 1));
  assign hit_b = (intv == INTV_N16) && (cnt == CW'(GROUP_B - 1));

  always_comb begin
    case (intv)
      INTV_EACH: ev = done;
      INTV_PASS: ev = done && last;
      default:   ev = done && (hit_a || hit_b);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (start) cnt <= '0;
      else if (done) cnt <= (hit_a || hit_b) ? '0 : cnt + 1'b1;
      if (ev) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SLOT_W     = 4,
  parameter int CONV_TICKS = 4,
  parameter int ACQ_BASE   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_hit,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic              sw_start,
  input  logic              flag_clr,
  input  logic [SLOT_W-1:0] slot_first,
  input  logic [SLOT_W-1:0] slot_last,
  input  logic              acq_ext_en,
  input  logic              ext_temp_mode,
  output logic              conv_tick,
  output logic              busy,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              sample_done,
  output logic              data_avail,
  output logic              irq,
  output logic              ref_internal
);
  ctl_t        ctl;
  logic [13:0] ctl_bits;
  logic        last_p;

  assign ctl_bits = ctl;

  adc_ctl_reg u_reg (
    .clk(clk), .rst(rst), .hit(bus_hit), .rd(bus_rd), .wr(bus_wr),
    .wdata(bus_wdata), .busy(busy), .ctl(ctl), .rdata(bus_rdata)
  );

  adc_clk_div u_div (
    .clk(clk), .rst(rst), .sel(ctl.clk_sel), .tick(conv_tick)
  );

  adc_seq_fsm #(.SLOT_W(SLOT_W), .CONV_TICKS(CONV_TICKS), .ACQ_BASE(ACQ_BASE)) u_fsm (
    .clk(clk), .rst(rst), .tick(conv_tick), .start(sw_start),
    .first(slot_first), .last(slot_last), .cont(ctl.cont),
    .acq_en(acq_ext_en), .acq_ext(ctl.acq), .busy(busy),
    .slot(cur_slot), .done_p(sample_done), .last_p(last_p)
  );

  adc_irq_pace u_pace (
    .clk(clk), .rst(rst), .start(sw_start && !busy), .done(sample_done),
    .last(last_p), .intv(ctl.intv), .clr(flag_clr), .flag(data_avail)
  );

  assign irq = data_avail && ctl.ie;

  always_ff @(posedge clk) begin
    if (rst) ref_internal <= 1'b0;
    else ref_internal <= ctl.iref || ext_temp_mode ||
                         (cur_slot == SLOT_W'(6)) || (cur_slot == SLOT_W'(7));
  end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic [13:0]       ctl_bits,
  input logic              conv_tick,
  input logic              sample_done,
  input logic              data_avail,
  input logic              flag_clr,
  input logic              ext_temp_mode,
  input logic              ref_internal
);
  a_r4_tick_single: assert property (@(posedge clk) disable iff (rst)
    conv_tick |=> !conv_tick);

  a_r5_locked_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(ctl_bits));

  a_r6_done_in_pass: assert property (@(posedge clk) disable iff (rst)
    sample_done |-> $past(busy));

  a_r9_clear_only: assert property (@(posedge clk) disable iff (rst)
    $fell(data_avail) |-> $past(flag_clr));

  a_r12_temp_ref: assert property (@(posedge clk) disable iff (rst)
    ext_temp_mode |=> ref_internal);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ctl_bits(ctl_bits),
  .conv_tick(conv_tick), .sample_done(sample_done), .data_avail(data_avail),
  .flag_clr(flag_clr), .ext_temp_mode(ext_temp_mode), .ref_internal(ref_internal)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_hit = 0, bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        sw_start = 0, flag_clr = 0;
  logic [3:0]  slot_first = '0, slot_last = '0;
  logic        acq_ext_en = 0, ext_temp_mode = 0;
  logic        conv_tick, busy, sample_done, data_avail, irq, ref_internal;
  logic [3:0]  cur_slot;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_hit(bus_hit), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sw_start(sw_start),
    .flag_clr(flag_clr), .slot_first(slot_first), .slot_last(slot_last),
    .acq_ext_en(acq_ext_en), .ext_temp_mode(ext_temp_mode), .conv_tick(conv_tick),
    .busy(busy), .cur_slot(cur_slot), .sample_done(sample_done),
    .data_avail(data_avail), .irq(irq), .ref_internal(ref_internal)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; sw_start = 0; flag_clr = 0; bus_hit = 0; bus_rd = 0; bus_wr = 0;
    acq_ext_en = 0; ext_temp_mode = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic reg_write(input logic [15:0] v);
    bus_hit = 1; bus_wr = 1; bus_wdata = v;
    @(negedge clk);
    bus_hit = 0; bus_wr = 0;
  endtask

  task automatic reg_read(output logic [15:0] v);
    bus_hit = 1; bus_rd = 1;
    @(negedge clk);
    bus_hit = 0; bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic start_pass(input logic [3:0] f, input logic [3:0] l);
    slot_first = f; slot_last = l;
    sw_start = 1;
    @(negedge clk);
    sw_start = 0;
  endtask

  task automatic wait_sample(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!sample_done && gap < 4000);
    if (!sample_done) check("timeout sample_done", 0, 1);
  endtask

  task automatic tick_gap(output int gap);
    int n = 0;
    do begin @(negedge clk); n++; end while (!conv_tick && n < 400);
    gap = 0;
    do begin @(negedge clk); gap++; end while (!conv_tick && gap < 400);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 data_avail", int'(data_avail), 0);
    check("R1 irq", int'(irq), 0);
    reg_read(v);
    check("R1 reset word", int'(v), 16'h3000);
  endtask

  task automatic t_readback();
    logic [15:0] v;
    do_reset();
    reg_write(16'hFFFF); reg_read(v);
    check("R2 reserved bits read 0", int'(v), 16'h7CEF);
    reg_write(16'h0000); reg_read(v);
    check("R3 code 000 floor", int'(v), 16'h3000);
    reg_write(16'h1000); reg_read(v);
    check("R3 code 001 floor", int'(v), 16'h3000);
    reg_write(16'h4000); reg_read(v);
    check("R3 code 100 kept", int'(v), 16'h4000);
  endtask

  task automatic t_divider();
    int g;
    do_reset();
    reg_write(16'h0000); tick_gap(g); check("R4 code 000 period", g, 16);
    reg_write(16'h5000); tick_gap(g); check("R4 code 101 period", g, 32);
    reg_write(16'h6000); tick_gap(g); check("R4 code 110 period", g, 64);
    reg_write(16'h7000); tick_gap(g); check("R4 code 111 period", g, 128);
    reg_write(16'h4000); tick_gap(g); check("R4 code 100 period", g, 16);
  endtask

  task automatic t_single_lock();
    logic [15:0] v;
    int g;
    do_reset();
    reg_write(16'h4000);
    start_pass(4'd2, 4'd4);
    check("R6 busy after start", int'(busy), 1);
    reg_write(16'h7FFF); reg_read(v);
    check("R5 write ignored while busy", int'(v), 16'h4000);
    wait_sample(g);
    check("R6 slot after 1st", int'(cur_slot), 3);
    sw_start = 1; @(negedge clk); sw_start = 0;
    wait_sample(g);
    check("R6 slot after 2nd", int'(cur_slot), 4);
    check("R6 busy before last", int'(busy), 1);
    wait_sample(g);
    check("R6 busy clears at last", int'(busy), 0);
    check("R6 slot held at last", int'(cur_slot), 4);
    reg_write(16'h5000); reg_read(v);
    check("R5 write accepted when idle", int'(v), 16'h5000);
  endtask

  task automatic t_continuous();
    int g;
    do_reset();
    reg_write(16'h0040);
    start_pass(4'd0, 4'd1);
    for (int k = 0; k < 5; k++) begin
      wait_sample(g);
      check("R7 wrap slot", int'(cur_slot), (k % 2 == 0) ? 1 : 0);
    end
    check("R7 still busy", int'(busy), 1);
  endtask

  task automatic t_interval_pass();
    int g;
    do_reset();
    reg_write(16'h0400);
    start_pass(4'd0, 4'd2);
    for (int k = 1; k <= 3; k++) begin
      wait_sample(g); @(negedge clk);
      check("R8 pass interval flag", int'(data_avail), (k == 3) ? 1 : 0);
    end
    check("R10 irq masked", int'(irq), 0);
    reg_write(16'h0420);
    check("R10 irq enabled", int'(irq), 1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R10 irq follows clear", int'(irq), 0);
  endtask

  task automatic t_interval_n(input logic [15:0] w, input int n, input string req);
    int g;
    int bad = 0;
    do_reset();
    reg_write(w);
    start_pass(4'd0, 4'd3);
    for (int k = 1; k <= n; k++) begin
      wait_sample(g); @(negedge clk);
      if (k < n && data_avail) bad++;
    end
    check({req, " early flag"}, bad, 0);
    check({req, " flag at boundary"}, int'(data_avail), 1);
  endtask

  task automatic t_each_priority();
    int g;
    do_reset();
    reg_write(16'h0040);
    start_pass(4'd0, 4'd0);
    wait_sample(g); @(negedge clk);
    check("R8 each-sample flag", int'(data_avail), 1);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R9 clear strobe", int'(data_avail), 0);
    wait_sample(g); @(negedge clk);
    check("R8 each-sample flag again", int'(data_avail), 1);
    repeat (10) @(negedge clk);
    check("R9 flag sticky", int'(data_avail), 1);
    wait_sample(g);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R9 event beats clear", int'(data_avail), 1);
  endtask

  task automatic t_acq(input logic en, input int exp, input string req);
    int g;
    do_reset();
    reg_write(16'h0003);
    acq_ext_en = en;
    start_pass(4'd0, 4'd2);
    wait_sample(g);
    wait_sample(g);
    check(req, g, exp);
  endtask

  task automatic t_ref();
    do_reset();
    reg_write(16'h0000);
    repeat (2) @(negedge clk);
    check("R12 external ref", int'(ref_internal), 0);
    ext_temp_mode = 1; repeat (2) @(negedge clk);
    check("R12 temp mode forces internal", int'(ref_internal), 1);
    ext_temp_mode = 0; reg_write(16'h0080); repeat (2) @(negedge clk);
    check("R12 enable bit", int'(ref_internal), 1);
    reg_write(16'h0000);
    start_pass(4'd6, 4'd7);
    repeat (3) @(negedge clk);
    check("R12 slot 6 forces internal", int'(ref_internal), 1);
  endtask

  initial begin
    t_reset();
    t_readback();
    t_divider();
    t_single_lock();
    t_continuous();
    t_interval_pass();
    t_interval_n(16'h0840, 12, "R8 every 12");
    t_interval_n(16'h0C40, 16, "R8 every 16");
    t_each_priority();
    t_acq(1'b1, 128, "R11 extended spacing");
    t_acq(1'b0, 80, "R11 extension disabled");
    t_ref();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule